// File: doc/BRIEF.md
# Three-Stage Buffered Crossbar Switch

This block is an N-by-N word switch that stores traffic at three points. Each input holds one small queue per output, so a word for a congested output does not hold back words bound elsewhere. Each input/output pair has its own crosspoint buffer. Each output has its own output queue, which feeds the output port. Two independent sets of round-robin arbiters move the traffic. One arbiter per input moves a word from one of its per-output queues into a crosspoint buffer that has room. One arbiter per output moves a word from one non-empty crosspoint buffer into its output queue when that queue has room.

Every input port presents a word with an N-bit destination bitmap under a valid/ready handshake. A single set bit is unicast, several set bits are multicast, and all bits set is broadcast. The input accepts the word in one cycle only when every selected per-output queue has room, and it writes one copy into each of those queues. Every output port presents the word and the index of the input it came from under valid/ready, and the port can hold the word off indefinitely.

Top module: `xq_switch`

## Requirements
- R1: While reset is asserted and right after it is released, every out_valid_o bit is 0 and every in_ready_o bit is 1, whatever destination bitmap is presented.
- R2: A word whose bitmap has exactly one bit set is delivered once, only at that output, with its data unchanged and out_src_o equal to the input index. On an idle switch with all outputs ready, the output offers it in the cycle that follows the second rising edge after the accepting edge.
- R3: A word whose bitmap has several bits set produces exactly one copy at each selected output and none at any other output. This holds for every non-zero bitmap, including all ones.
- R4: A word presented with an all-zero bitmap is accepted (in_ready_o high) and is discarded without reaching any output.
- R5: in_ready_o of an input is low while any per-output queue selected by its bitmap is full. With an output held off, one input streaming to that output is accepted exactly VOQ_DEPTH + XP_DEPTH + OQ_DEPTH words.
- R6: While one output is held off, the same input still accepts words for other outputs, and those words are delivered.
- R7: Under random traffic and random output backpressure, the words of each input/output pair leave in the order they were accepted, with none lost and none duplicated.
- R8: Each output arbiter grants at most one crosspoint per cycle. When every input has a word waiting for the same output, the sources are served one per cycle in ascending cyclic index order.
- R9: Each input arbiter writes at most one crosspoint buffer per cycle, and its pointer does not move in a cycle with no request. A broadcast word on an idle switch appears at the outputs on consecutive cycles in ascending cyclic output order.
- R10: While out_valid_o is high and out_ready_i is low on an output, out_valid_o stays high and out_data_o stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NPORT | Per-input word valid |
| in_data_i | input | NPORT*DW | Per-input word, input i at bits [i*DW +: DW] |
| in_dest_i | input | NPORT*NPORT | Per-input destination bitmap, input i at bits [i*NPORT +: NPORT], bit j selects output j |
| in_ready_o | output | NPORT | Per-input accept |
| out_valid_o | output | NPORT | Per-output word valid |
| out_data_o | output | NPORT*DW | Per-output word, output j at bits [j*DW +: DW] |
| out_src_o | output | NPORT*SW | Index of the source input, output j at bits [j*SW +: SW] |
| out_ready_i | input | NPORT | Per-output accept |

## Verification
The assertions check three things on every cycle. No queue is written while full or read while empty. Each arbiter issues at most one grant, and only to a requester. An output that is held off keeps its word stable. Other properties depend on whole traffic patterns, and only the bench scenarios can show them. These are the exact accept count before backpressure reaches an input, the cyclic service order under contention and for a broadcast, the discarding of zero-bitmap words, and the per-pair ordering under random traffic. The bench checks the copy count for every non-zero bitmap from every input of a 4-port instance.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int XQ_DEF_PORTS = 8;
  localparam int XQ_DEF_WIDTH = 32;

  function automatic int xq_idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xq_fifo.sv
module xq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R7
endmodule

// File: rtl/xq_rr_arb.sv
module xq_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, win;
  logic          found;
  int            idx;

  // first requester at or after the pointer, cyclically
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    win   = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end

  AST_GNT_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R8
  AST_GNT_WHEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> $onehot(gnt_o)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/xq_switch.sv
module xq_switch
  import xq_pkg::*;
#(
  parameter int NPORT     = XQ_DEF_PORTS,
  parameter int DW        = XQ_DEF_WIDTH,
  parameter int VOQ_DEPTH = 2,
  parameter int XP_DEPTH  = 2,
  parameter int OQ_DEPTH  = 4,
  localparam int SW       = xq_idx_width(NPORT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPORT-1:0]    in_valid_i,
  input  logic [NPORT*DW-1:0] in_data_i,
  input  logic [NPORT*NPORT-1:0] in_dest_i,
  output logic [NPORT-1:0]    in_ready_o,
  output logic [NPORT-1:0]    out_valid_o,
  output logic [NPORT*DW-1:0] out_data_o,
  output logic [NPORT*SW-1:0] out_src_o,
  input  logic [NPORT-1:0]    out_ready_i
);
  localparam int TW = SW + DW;

  // [i][j]: input i, output j
  logic [NPORT-1:0][NPORT-1:0] voq_full, voq_empty, in_gnt, xp_full, xp_empty;
  // [j][i]: output j, input i
  logic [NPORT-1:0][NPORT-1:0] out_req, out_gnt;
  logic [DW-1:0] voq_rdata [NPORT][NPORT];
  logic [TW-1:0] xp_rdata  [NPORT][NPORT];
  logic [TW-1:0] oq_wdata  [NPORT];
  logic [TW-1:0] oq_rdata  [NPORT];
  logic [NPORT-1:0] oq_full, oq_empty, oq_push, oq_pop;

  always_comb begin
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        out_req[j][i] = !xp_empty[i][j] && !oq_full[j];
      end
    end
  end

  // one-hot mux of the granted crosspoint into each output queue
  always_comb begin
    for (int j = 0; j < NPORT; j++) begin
      oq_wdata[j] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (out_gnt[j][i]) oq_wdata[j] = oq_wdata[j] | xp_rdata[i][j];
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [NPORT-1:0] dest;
    assign dest          = in_dest_i[i*NPORT +: NPORT];
    assign in_ready_o[i] = &(~voq_full[i] | ~dest);

    xq_rr_arb #(.N(NPORT)) u_in_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (~voq_empty[i] & ~xp_full[i]),
      .gnt_o (in_gnt[i])
    );

    for (genvar j = 0; j < NPORT; j++) begin : g_xp
      xq_fifo #(.DW(DW), .DEPTH(VOQ_DEPTH)) u_voq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (in_valid_i[i] && in_ready_o[i] && dest[j]),
        .wdata_i(in_data_i[i*DW +: DW]),
        .pop_i  (in_gnt[i][j]),
        .rdata_o(voq_rdata[i][j]),
        .empty_o(voq_empty[i][j]),
        .full_o (voq_full[i][j])
      );

      xq_fifo #(.DW(TW), .DEPTH(XP_DEPTH)) u_xp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (in_gnt[i][j]),
        .wdata_i({SW'(i), voq_rdata[i][j]}),
        .pop_i  (out_gnt[j][i]),
        .rdata_o(xp_rdata[i][j]),
        .empty_o(xp_empty[i][j]),
        .full_o (xp_full[i][j])
      );
    end

    AST_ONE_XP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(in_gnt[i])); // R9
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    xq_rr_arb #(.N(NPORT)) u_out_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (out_req[j]),
      .gnt_o (out_gnt[j])
    );

    assign oq_push[j] = |out_gnt[j];
    assign oq_pop[j]  = out_valid_o[j] && out_ready_i[j];

    xq_fifo #(.DW(TW), .DEPTH(OQ_DEPTH)) u_oq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (oq_push[j]),
      .wdata_i(oq_wdata[j]),
      .pop_i  (oq_pop[j]),
      .rdata_o(oq_rdata[j]),
      .empty_o(oq_empty[j]),
      .full_o (oq_full[j])
    );

    assign out_valid_o[j]           = !oq_empty[j];
    assign out_data_o[j*DW +: DW]   = oq_rdata[j][DW-1:0];
    assign out_src_o[j*SW +: SW]    = oq_rdata[j][TW-1:DW];

    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[j] && !out_ready_i[j]) |=>
      (out_valid_o[j] && $stable(out_data_o[j*DW +: DW]))); // R10
  end
endmodule

// File: tb/xq_switch_tb_top.sv
module xq_switch_tb_top;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int SW = 2;
  localparam int VD = 2;
  localparam int XD = 2;
  localparam int OD = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic [N-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [N*DW-1:0] in_data, out_data;
  logic [N*N-1:0]  in_dest;
  logic [N*SW-1:0] out_src;

  xq_switch #(.NPORT(N), .DW(DW), .VOQ_DEPTH(VD), .XP_DEPTH(XD), .OQ_DEPTH(OD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_dest_i(in_dest), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_src_o(out_src), .out_ready_i(out_ready)
  );

  logic [N-1:0]  pv, nr;
  logic [DW-1:0] pd [N];
  logic [N-1:0]  pm [N];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int acc_cyc [N];
  bit acc_last [N];
  bit lat_on = 0;
  bit done = 0;
  string tag = "R1";
  logic [DW-1:0] exp_q [N][N][$];
  int exp_t [N][N][$];
  int src_log [N][$];
  int cyc_log [N][$];

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic step();
    int s;
    logic [DW-1:0] d, e;
    int t0;
    @(negedge clk_i);
    cyc++;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = pv[i];
      in_data[i*DW +: DW] = pd[i];
      in_dest[i*N +: N] = pm[i];
    end
    out_ready = nr;
    #1;
    for (int j = 0; j < N; j++) begin
      if (out_valid[j] && out_ready[j]) begin
        s = int'(out_src[j*SW +: SW]);
        d = out_data[j*DW +: DW];
        src_log[j].push_back(s);
        cyc_log[j].push_back(cyc);
        if (exp_q[s][j].size() == 0) begin
          chk(1'b0, {tag, " unexpected word"}, int'(d), -1);
        end else begin
          e  = exp_q[s][j].pop_front();
          t0 = exp_t[s][j].pop_front();
          chk(d == e, {tag, " data"}, int'(d), int'(e));
          if (lat_on) chk(cyc - t0 == 3, "R2 latency", cyc - t0, 3);
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      acc_last[i] = pv[i] && in_ready[i];
      if (acc_last[i]) begin
        acc_cyc[i] = cyc;
        for (int j = 0; j < N; j++) begin
          if (pm[i][j]) begin
            exp_q[i][j].push_back(pd[i]);
            exp_t[i][j].push_back(cyc);
          end
        end
        pv[i] = 1'b0;
      end
    end
  endtask

  task automatic clear_logs();
    for (int j = 0; j < N; j++) begin
      src_log[j].delete();
      cyc_log[j].delete();
    end
  endtask

  task automatic drain(input int cycles);
    int left;
    pv = '0;
    nr = '1;
    repeat (cycles) step();
    left = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) left += exp_q[i][j].size();
    chk(left == 0, "R7 words left undelivered", left, 0);
  endtask

  function automatic int total_log();
    int n = 0;
    for (int j = 0; j < N; j++) n += src_log[j].size();
    return n;
  endfunction

  initial begin
    int idx [N];
    int cnt, first, j0, m;
    logic [DW-1:0] d0;
    pv = '0;
    nr = '1;
    for (int i = 0; i < N; i++) begin
      pd[i] = '0;
      pm[i] = '1;
    end
    in_valid  = '0;
    in_data   = '0;
    in_dest   = '1;
    out_ready = '1;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready in reset", int'(in_ready), 15);
    rst_ni = 1'b1;
    step();
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready after reset", int'(in_ready), 15);

    // R2: unicast with idle latency
    tag = "R2";
    lat_on = 1;
    clear_logs();
    pv[1] = 1'b1; pd[1] = 16'h1234; pm[1] = 4'b0100;
    step();
    drain(10);
    pv[0] = 1'b1; pd[0] = 16'h0abc; pm[0] = 4'b1000;
    step();
    drain(10);
    lat_on = 0;
    chk(total_log() == 2, "R2 delivery count", total_log(), 2);

    // R4: zero bitmap discarded
    tag = "R4";
    clear_logs();
    pv[3] = 1'b1; pd[3] = 16'hdead; pm[3] = '0;
    step();
    chk(acc_last[3], "R4 zero bitmap accepted", int'(acc_last[3]), 1);
    drain(12);
    chk(total_log() == 0, "R4 nothing delivered", total_log(), 0);

    // R3: every non-zero bitmap from every input
    tag = "R3";
    clear_logs();
    for (int i = 0; i < N; i++) idx[i] = 1;
    cnt = 0;
    while (cnt < 200 && (idx[0] < 16 || idx[1] < 16 || idx[2] < 16 || idx[3] < 16 || pv != '0)) begin
      for (int i = 0; i < N; i++) begin
        if (!pv[i] && idx[i] < 16) begin
          pv[i] = 1'b1;
          pm[i] = 4'(idx[i]);
          pd[i] = 16'((i << 8) | idx[i]);
          idx[i]++;
        end
      end
      step();
      cnt++;
    end
    drain(30);
    chk(total_log() == N * 32, "R3 total copies", total_log(), N * 32);

    // R9: broadcast fans out one output per cycle in cyclic order
    tag = "R9";
    clear_logs();
    pv[0] = 1'b1; pd[0] = 16'h00b0; pm[0] = '1;
    step();
    drain(12);
    first = 1 << 30;
    j0 = 0;
    for (int j = 0; j < N; j++) begin
      chk(cyc_log[j].size() == 1, "R9 one copy per output", cyc_log[j].size(), 1);
      if (cyc_log[j].size() > 0 && cyc_log[j][0] < first) begin
        first = cyc_log[j][0];
        j0 = j;
      end
    end
    chk(first - acc_cyc[0] == 3, "R9 first copy timing", first - acc_cyc[0], 3);
    for (int k = 1; k < N; k++) begin
      m = (j0 + k) % N;
      if (cyc_log[m].size() > 0)
        chk(cyc_log[m][0] == first + k, "R9 cyclic output order", cyc_log[m][0], first + k);
    end

    // R8 and R10: all inputs contend for output 0 while it is held off
    tag = "R8";
    clear_logs();
    nr = 4'b1110;
    for (int i = 0; i < N; i++) begin
      pv[i] = 1'b1; pd[i] = 16'(16'h0100 + i); pm[i] = 4'b0001;
    end
    step();
    repeat (4) step();
    d0 = out_data[DW-1:0];
    chk(out_valid[0], "R10 held word valid", int'(out_valid[0]), 1);
    repeat (4) begin
      step();
      chk(out_valid[0] && out_data[DW-1:0] == d0, "R10 held word stable", int'(out_data[DW-1:0]), int'(d0));
    end
    drain(12);
    chk(src_log[0].size() == N, "R8 words served", src_log[0].size(), N);
    for (int k = 0; k + 1 < src_log[0].size(); k++)
      chk(src_log[0][k+1] == (src_log[0][k] + 1) % N, "R8 cyclic source order",
          src_log[0][k+1], (src_log[0][k] + 1) % N);

    // R5 and R6: output 1 held off, input 2 streams to it
    tag = "R5";
    clear_logs();
    nr = 4'b1101;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      pv[2] = 1'b1; pd[2] = 16'(16'h0200 + k); pm[2] = 4'b0010;
      step();
      if (acc_last[2]) cnt++;
    end
    pv[2] = 1'b0;
    chk(cnt == VD + XD + OD, "R5 accepted before backpressure", cnt, VD + XD + OD);
    pm[2] = 4'b1010;
    step();
    chk(!in_ready[2], "R5 multicast to full queue refused", int'(in_ready[2]), 0);
    tag = "R6";
    pm[2] = 4'b1000;
    step();
    chk(in_ready[2], "R6 other output still open", int'(in_ready[2]), 1);
    for (int k = 0; k < 3; k++) begin
      pv[2] = 1'b1; pd[2] = 16'(16'h0300 + k); pm[2] = 4'b1000;
      step();
    end
    pv[2] = 1'b0;
    repeat (8) step();
    chk(src_log[3].size() == 3, "R6 delivered past blocked output", src_log[3].size(), 3);
    chk(src_log[1].size() == 0, "R5 blocked output silent", src_log[1].size(), 0);
    tag = "R7";
    drain(30);
    chk(src_log[1].size() == VD + XD + OD, "R7 blocked words released", src_log[1].size(), VD + XD + OD);

    // R7: random traffic with random backpressure
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) begin
        if (!pv[i] && ($urandom % 3) != 0) begin
          pv[i] = 1'b1;
          pd[i] = 16'($urandom);
          pm[i] = 4'(($urandom % 15) + 1);
        end
      end
      for (int j = 0; j < N; j++) nr[j] = (($urandom % 10) < 7);
      step();
    end
    drain(80);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule